// File: doc/BRIEF.md
# Multiplexed MDIO Management Master

This block is an MDIO management master driven from a small 32-bit register bus. One serial engine serves two groups of downstream management buses, an internal group and an external group. Software programs a parameter word, which holds the bus choice, the PHY address, the frame format and the write data. It then writes the register address and issues a read or write command. The engine runs the management frame on the chosen bus only, raises a done flag in the status register, and returns any read data through a dedicated register.

Each bus group has its own clock-rate register, so the internal and external buses can run at different MDC speeds. Every rate register holds a divisor in bits 15:0 and a dividend in bits 31:16. In Clause-45 mode one command issues an address frame followed by the read or write frame. A lockout bit in the scan control register is brought out as a pin that keeps an external management master off the shared buses.

Top module: `mdio_mux_master`

## Requirements
- R1: After reset every register reads 0, the done flag is 0, and all MDC, output-enable and lockout pins are low. MDC and output-enable stay low on every bus while no transaction is running.
- R2: Registers sit at these byte offsets. 0x000 is the external rate (32 bits). 0x004 is the internal rate (32 bits). 0x008 is scan control (32 bits). 0x23C is the parameter word (bits 25:0 stored, upper bits read 0). 0x244 is the register address (bits 20:0 stored). 0x240 is read data. 0x248 is control. 0x24C is status, with done in bit 0. Any unmapped offset reads 0.
- R3: The parameter word fields are: data 15:0, PHY address 20:16, Clause-45 select 21, bus number 24:22, internal select 25. With bit 25 set, bus port index = bus number. With bit 25 clear, index = 8 + bus number. Only the selected port toggles MDC or enables its output.
- R4: A Clause-22 write sends these bits MSB first: 32 ones, start 01, opcode 01, PHY address, register address bits 4:0, turnaround 10, then 16 data bits.
- R5: A Clause-22 read uses opcode 10 and releases output-enable from the turnaround (bit 46 of the 64-bit frame) to the end of the frame. It samples MDIO on the rising MDC edge. The 16 bits received MSB first appear in bits 15:0 of read data, and bits 31:16 read 0.
- R6: With Clause-45 select set, an address frame goes out first. It has start 00, opcode 00, device address (address bits 20:16), turnaround 10 and address bits 15:0. A second frame follows with start 00, opcode 01 for a write or 11 for a read, and the same device field. Done is raised only after both frames.
- R7: MDC half period, in core clocks, is max(1, floor(divisor*(dividend+1)/2)). The internal group uses the rate register at 0x004 and the external group uses 0x000. MDC runs without gaps across the two frames of a Clause-45 command.
- R8: Writing 1 to control starts a write and writing 2 starts a read. Any other nonzero value starts nothing. Done clears when control is written 0 or a command is accepted, and it sets when the last frame ends.
- R9: A command written while a transaction runs is ignored. Writing 0 to control aborts a running transaction at once, with MDC parked low.
- R10: The parameter word, address and selected rate are captured when a command is accepted. Register writes during a transaction do not alter its frames or MDC timing.
- R11: Bit 28 of scan control drives the management lockout output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mgmt_lockout | output | 1 | Keeps an external management master off the buses |
| mdc | output | 2*BUSES_PER_GROUP | Management clock per bus port |
| mdio_o | output | 2*BUSES_PER_GROUP | Serial data out per bus port |
| mdio_oe | output | 2*BUSES_PER_GROUP | Output enable per bus port |
| mdio_i | input | 2*BUSES_PER_GROUP | Serial data in per bus port |

## Verification
Register writes and frame serialization can land in the same cycle, because software keeps access to the register bus while a frame is shifting out. The bench starts a transaction and then, partway through the frame, rewrites the parameter word, the address and the rate, and issues a second command. It judges the result from the captured frame bits, the MDC edge spacing, the edge count and the single done event, which must all match the values captured at the original start. A control write of 0 landing during a frame is treated the same way: MDC must stop, and done must stay clear.

// File: rtl/mdio_mux_pkg.sv
package mdio_mux_pkg;

  localparam logic [9:0] OFS_RATE_EXT = 10'h000;
  localparam logic [9:0] OFS_RATE_INT = 10'h004;
  localparam logic [9:0] OFS_SCAN     = 10'h008;
  localparam logic [9:0] OFS_PARAM    = 10'h23C;
  localparam logic [9:0] OFS_RDATA    = 10'h240;
  localparam logic [9:0] OFS_ADDR     = 10'h244;
  localparam logic [9:0] OFS_CTRL     = 10'h248;
  localparam logic [9:0] OFS_STAT     = 10'h24C;

  localparam int LOCK_BIT    = 28;
  localparam int FRAME_BITS  = 64;
  localparam int TA_POS      = 46;
  localparam int DATA_POS    = 48;

  typedef enum logic [1:0] {ENG_IDLE, ENG_C45_ADR, ENG_XFER} eng_state_e;

  // field order follows the parameter word layout (bit 25 down to bit 0)
  typedef struct packed {
    logic        int_sel;
    logic [2:0]  bus;
    logic        c45;
    logic [4:0]  phy;
    logic [15:0] data;
  } param_t;

  function automatic logic [63:0] mk_frame(logic [1:0] st, logic [1:0] op,
                                           logic [4:0] phy, logic [4:0] ra,
                                           logic [1:0] ta, logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, phy, ra, ta, d};
  endfunction

  function automatic logic [63:0] c45_addr_frame(param_t p, logic [20:0] a);
    return mk_frame(2'b00, 2'b00, p.phy, a[20:16], 2'b10, a[15:0]);
  endfunction

  function automatic logic [63:0] xfer_frame(param_t p, logic [20:0] a, logic rd);
    logic [1:0] st, op;
    logic [4:0] ra;
    st = p.c45 ? 2'b00 : 2'b01;
    op = rd ? (p.c45 ? 2'b11 : 2'b10) : 2'b01;
    ra = p.c45 ? a[20:16] : a[4:0];
    return mk_frame(st, op, p.phy, ra, rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : p.data);
  endfunction

  // MDC half period in core clocks from divisor and dividend
  function automatic logic [32:0] mdc_half(logic [15:0] dv, logic [15:0] dd);
    logic [32:0] prod;
    prod = 33'(dv) * (33'(dd) + 33'd1);
    prod = prod >> 1;
    return (prod == '0) ? 33'd1 : prod;
  endfunction

endpackage

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_mux_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              busy_i,
  input  logic              fin_i,
  input  logic [15:0]       rd_word_i,
  output logic              start_o,
  output logic              abort_o,
  output logic              is_read_o,
  output param_t            param_o,
  output logic [20:0]       addr_o,
  output logic [31:0]       rate_ext_o,
  output logic [31:0]       rate_int_o,
  output logic              lockout_o,
  output logic              done_o
);

  logic [31:0] rate_ext_q, rate_int_q, scan_q;
  param_t      param_q;
  logic [20:0] addr_q;
  logic [1:0]  ctrl_q;
  logic        done_q;
  logic        ctrl_wr;

  function automatic logic hit(logic [ADDR_W-1:0] a, logic [9:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign ctrl_wr   = reg_we_i && hit(reg_addr_i, OFS_CTRL);
  assign start_o   = ctrl_wr && !busy_i && (reg_wdata_i == 32'd1 || reg_wdata_i == 32'd2);
  assign abort_o   = ctrl_wr && (reg_wdata_i == 32'd0);
  assign is_read_o = reg_wdata_i[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_ext_q <= '0;
      rate_int_q <= '0;
      scan_q     <= '0;
      param_q    <= '0;
      addr_q     <= '0;
      ctrl_q     <= '0;
      done_q     <= 1'b0;
    end else begin
      if (reg_we_i) begin
        if (hit(reg_addr_i, OFS_RATE_EXT)) rate_ext_q <= reg_wdata_i;
        if (hit(reg_addr_i, OFS_RATE_INT)) rate_int_q <= reg_wdata_i;
        if (hit(reg_addr_i, OFS_SCAN))     scan_q     <= reg_wdata_i;
        if (hit(reg_addr_i, OFS_PARAM))    param_q    <= reg_wdata_i[25:0];
        if (hit(reg_addr_i, OFS_ADDR))     addr_q     <= reg_wdata_i[20:0];
        if (ctrl_wr)                       ctrl_q     <= reg_wdata_i[1:0];
      end
      // clear wins over completion
      if (abort_o || start_o) done_q <= 1'b0;
      else if (fin_i)         done_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if      (hit(reg_addr_i, OFS_RATE_EXT)) reg_rdata_o = rate_ext_q;
    else if (hit(reg_addr_i, OFS_RATE_INT)) reg_rdata_o = rate_int_q;
    else if (hit(reg_addr_i, OFS_SCAN))     reg_rdata_o = scan_q;
    else if (hit(reg_addr_i, OFS_PARAM))    reg_rdata_o = {6'd0, param_q};
    else if (hit(reg_addr_i, OFS_RDATA))    reg_rdata_o = {16'd0, rd_word_i};
    else if (hit(reg_addr_i, OFS_ADDR))     reg_rdata_o = {11'd0, addr_q};
    else if (hit(reg_addr_i, OFS_CTRL))     reg_rdata_o = {30'd0, ctrl_q};
    else if (hit(reg_addr_i, OFS_STAT))     reg_rdata_o = {31'd0, done_q};
  end

  assign param_o    = param_q;
  assign addr_o     = addr_q;
  assign rate_ext_o = rate_ext_q;
  assign rate_int_o = rate_int_q;
  assign lockout_o  = scan_q[LOCK_BIT];
  assign done_o     = done_q;

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_mux_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        abort_i,
  input  logic        is_read_i,
  input  param_t      param_i,
  input  logic [20:0] addr_i,
  input  logic [32:0] half_i,
  input  logic        mdi_i,
  output logic        busy_o,
  output logic        mdc_o,
  output logic        mdo_o,
  output logic        moe_o,
  output logic        fin_o,
  output logic        rise_o,
  output param_t      lat_param_o,
  output logic [15:0] rd_word_o
);

  eng_state_e  st_q;
  param_t      par_q;
  logic [20:0] adr_q;
  logic        rdm_q, mdc_q;
  logic [32:0] half_q, hcnt_q;
  logic [63:0] sh_q;
  logic [5:0]  bit_q;
  logic [15:0] rdw_q;
  logic        tick, rise, fall, frame_end, in_rd_phase;

  assign busy_o      = (st_q != ENG_IDLE);
  assign tick        = busy_o && (hcnt_q == half_q - 33'd1);
  assign rise        = tick && !mdc_q;
  assign fall        = tick && mdc_q;
  assign frame_end   = fall && (bit_q == 6'(FRAME_BITS - 1));
  assign fin_o       = frame_end && (st_q == ENG_XFER);
  assign in_rd_phase = rdm_q && (st_q == ENG_XFER) && (int'(bit_q) >= TA_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      par_q  <= '0;
      adr_q  <= '0;
      rdm_q  <= 1'b0;
      mdc_q  <= 1'b0;
      half_q <= 33'd1;
      hcnt_q <= '0;
      sh_q   <= '0;
      bit_q  <= '0;
      rdw_q  <= '0;
    end else if (abort_i) begin
      st_q   <= ENG_IDLE;
      mdc_q  <= 1'b0;
      hcnt_q <= '0;
    end else if (start_i && !busy_o) begin
      par_q  <= param_i;
      adr_q  <= addr_i;
      rdm_q  <= is_read_i;
      half_q <= half_i;
      hcnt_q <= '0;
      bit_q  <= '0;
      mdc_q  <= 1'b0;
      sh_q   <= param_i.c45 ? c45_addr_frame(param_i, addr_i)
                            : xfer_frame(param_i, addr_i, is_read_i);
      st_q   <= param_i.c45 ? ENG_C45_ADR : ENG_XFER;
    end else if (busy_o) begin
      hcnt_q <= tick ? '0 : hcnt_q + 33'd1;
      if (rise) begin
        mdc_q <= 1'b1;
        if (rdm_q && st_q == ENG_XFER && int'(bit_q) >= DATA_POS)
          rdw_q <= {rdw_q[14:0], mdi_i};
      end
      if (fall) begin
        mdc_q <= 1'b0;
        if (frame_end) begin
          bit_q <= '0;
          if (st_q == ENG_C45_ADR) begin
            st_q <= ENG_XFER;
            sh_q <= xfer_frame(par_q, adr_q, rdm_q);
          end else begin
            st_q <= ENG_IDLE;
          end
        end else begin
          bit_q <= bit_q + 6'd1;
          sh_q  <= {sh_q[62:0], 1'b0};
        end
      end
    end
  end

  assign mdc_o       = mdc_q;
  assign moe_o       = busy_o && !in_rd_phase;
  assign mdo_o       = moe_o && sh_q[63];
  assign rise_o      = rise;
  assign lat_param_o = par_q;
  assign rd_word_o   = rdw_q;

endmodule

// File: rtl/mdio_bus_fanout.sv
module mdio_bus_fanout #(
  parameter int PER_GRP = 8,
  localparam int NUM_BUS = 2 * PER_GRP
) (
  input  logic               en_i,
  input  logic               int_sel_i,
  input  logic [2:0]         bus_i,
  input  logic               mdc_i,
  input  logic               mdo_i,
  input  logic               moe_i,
  output logic               mdi_o,
  output logic [NUM_BUS-1:0] mdc_o,
  output logic [NUM_BUS-1:0] mdio_o,
  output logic [NUM_BUS-1:0] mdio_oe,
  input  logic [NUM_BUS-1:0] mdio_i
);

  logic [NUM_BUS-1:0] sel;

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_port
    localparam logic       IS_INT = (g < PER_GRP);
    localparam logic [2:0] IDX    = 3'(g % PER_GRP);
    assign sel[g]     = en_i && (int_sel_i == IS_INT) && (bus_i == IDX);
    assign mdc_o[g]   = sel[g] && mdc_i;
    assign mdio_o[g]  = sel[g] && mdo_i;
    assign mdio_oe[g] = sel[g] && moe_i;
  end

  assign mdi_o = |(sel & mdio_i);

endmodule

// File: rtl/mdio_mux_master.sv
module mdio_mux_master
  import mdio_mux_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BUSES_PER_GROUP = 8,
  localparam int NUM_BUS = 2 * BUSES_PER_GROUP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               mgmt_lockout,
  output logic [NUM_BUS-1:0] mdc,
  output logic [NUM_BUS-1:0] mdio_o,
  output logic [NUM_BUS-1:0] mdio_oe,
  input  logic [NUM_BUS-1:0] mdio_i
);

  logic        start_w, abort_w, is_read_w, busy_w, fin_w, done_w, rise_w;
  logic        eng_mdc, eng_mdo, eng_moe, sel_mdi;
  param_t      live_par_w, lat_par_w;
  logic [20:0] live_addr_w;
  logic [31:0] rate_ext_w, rate_int_w, rate_sel_w;
  logic [32:0] half_w;
  logic [15:0] rd_word_w;

  mdio_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .busy_i(busy_w), .fin_i(fin_w), .rd_word_i(rd_word_w),
    .start_o(start_w), .abort_o(abort_w), .is_read_o(is_read_w),
    .param_o(live_par_w), .addr_o(live_addr_w),
    .rate_ext_o(rate_ext_w), .rate_int_o(rate_int_w),
    .lockout_o(mgmt_lockout), .done_o(done_w)
  );

  assign rate_sel_w = live_par_w.int_sel ? rate_int_w : rate_ext_w;
  assign half_w     = mdc_half(rate_sel_w[15:0], rate_sel_w[31:16]);

  mdio_frame_eng u_eng (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_w), .abort_i(abort_w), .is_read_i(is_read_w),
    .param_i(live_par_w), .addr_i(live_addr_w), .half_i(half_w),
    .mdi_i(sel_mdi),
    .busy_o(busy_w), .mdc_o(eng_mdc), .mdo_o(eng_mdo), .moe_o(eng_moe),
    .fin_o(fin_w), .rise_o(rise_w),
    .lat_param_o(lat_par_w), .rd_word_o(rd_word_w)
  );

  mdio_bus_fanout #(.PER_GRP(BUSES_PER_GROUP)) u_fan (
    .en_i(busy_w), .int_sel_i(lat_par_w.int_sel), .bus_i(lat_par_w.bus),
    .mdc_i(eng_mdc), .mdo_i(eng_mdo), .moe_i(eng_moe),
    .mdi_o(sel_mdi),
    .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

endmodule

// File: rtl/mdio_mux_master_chk.sv
module mdio_mux_master_chk #(
  parameter int NUM_BUS = 16,
  parameter int ADDR_W  = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_BUS-1:0] mdc,
  input logic [NUM_BUS-1:0] mdio_oe,
  input logic               busy,
  input logic               fin,
  input logic               done,
  input logic               abort,
  input logic               rise,
  input logic [25:0]        lat_param,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [31:0]        reg_rdata
);

  assert_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mdc));

  assert_one_driver_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mdio_oe));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mdc == '0 && mdio_oe == '0));

  assert_done_after_last_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fin));

  assert_abort_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!done && !busy));

  assert_latched_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin && !abort) |=> (busy && $stable(lat_param)));

  assert_rise_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> busy);

  assert_rdata_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(10'h240)) |-> (reg_rdata[31:16] == 16'd0));

endmodule

bind mdio_mux_master mdio_mux_master_chk #(.NUM_BUS(NUM_BUS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_oe(mdio_oe),
  .busy(busy_w), .fin(fin_w), .done(done_w), .abort(abort_w), .rise(rise_w),
  .lat_param(lat_par_w), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/mdio_mux_master_tb_top.sv
module mdio_mux_master_tb_top;
  localparam int NB = 16;
  localparam logic [9:0] A_REXT = 10'h000, A_RINT = 10'h004, A_SCAN = 10'h008,
                         A_PAR = 10'h23C, A_RD = 10'h240, A_ADR = 10'h244,
                         A_CTL = 10'h248, A_ST = 10'h24C;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [9:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          lockout;
  logic [NB-1:0] mdc, mdio_o, mdio_oe;
  logic [NB-1:0] mdio_i = '0;

  int n_chk = 0, n_bad = 0;
  int exp_idx = 0, exp_half = 1, nrise = 0, other_rise = 0, gap_bad = 0;
  int cyc = 0, last_rise = 0;
  logic [15:0]   resp = '0;
  logic [NB-1:0] prev_mdc = '0;
  logic [127:0]  cap_o = '0, cap_oe = '0;
  logic cur_c45 = 1'b0, cur_rd = 1'b0;
  logic [4:0] cur_phy = '0;
  logic [20:0] cur_a = '0;
  logic [15:0] cur_d = '0;
  int half_ext = 1, half_int = 1;

  mdio_mux_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mgmt_lockout(lockout),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // bus monitor and PHY responder
  always @(negedge clk) begin
    int pos;
    cyc++;
    for (int k = 0; k < NB; k++) begin
      if (mdc[k] && !prev_mdc[k]) begin
        if (k == exp_idx) begin
          if (nrise < 128) begin
            cap_o[nrise]  = mdio_o[k];
            cap_oe[nrise] = mdio_oe[k];
          end
          if (nrise > 0 && (cyc - last_rise) != 2 * exp_half) gap_bad++;
          last_rise = cyc;
          nrise++;
        end else begin
          other_rise++;
        end
      end
    end
    prev_mdc = mdc;
    pos = nrise % 64;
    mdio_i = '0;
    mdio_i[exp_idx] = (pos >= 48) ? resp[63 - pos] : 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic int tb_half(int dv, int dd);
    int h;
    h = (dv * (dd + 1)) / 2;
    return (h < 1) ? 1 : h;
  endfunction

  // expected frame, first transmitted bit in bit 63
  function automatic logic [63:0] tb_frame(bit adr_frm, bit c45, bit rdop,
                                           logic [4:0] phy, logic [20:0] a, logic [15:0] d);
    logic [63:0] f;
    f = '1;
    f[31:30] = c45 ? 2'b00 : 2'b01;
    if (adr_frm)   f[29:28] = 2'b00;
    else if (rdop) f[29:28] = c45 ? 2'b11 : 2'b10;
    else           f[29:28] = 2'b01;
    f[27:23] = phy;
    f[22:18] = c45 ? a[20:16] : a[4:0];
    f[17:16] = 2'b10;
    f[15:0]  = adr_frm ? a[15:0] : d;
    return f;
  endfunction

  task automatic start_txn(input bit isel, input logic [2:0] bus, input bit c45, input bit rdop,
                           input logic [4:0] phy, input logic [20:0] a, input logic [15:0] d,
                           input logic [15:0] rsp);
    logic [31:0] v;
    exp_idx  = isel ? int'(bus) : NB / 2 + int'(bus);
    exp_half = isel ? half_int : half_ext;
    resp = rsp; cur_c45 = c45; cur_rd = rdop; cur_phy = phy; cur_a = a; cur_d = d;
    wr(A_PAR, {6'd0, isel, bus, c45, phy, d});
    wr(A_ADR, {11'd0, a});
    wr(A_CTL, 32'd0);
    rd(A_ST, v);
    chk("R8 done clear after control 0", 64'(v[0]), 64'd0);
    nrise = 0; other_rise = 0; gap_bad = 0;
    wr(A_CTL, rdop ? 32'd2 : 32'd1);
  endtask

  task automatic finish_txn();
    logic [31:0] v;
    logic [63:0] f, cw, co, m, eo;
    int nf;
    string tag;
    v = '0;
    for (int n = 0; n < 40000; n++) begin
      rd(A_ST, v);
      if (v[0]) break;
    end
    chk("R8 done set", 64'(v[0]), 64'd1);
    nf = cur_c45 ? 2 : 1;
    tag = cur_c45 ? "R6 frame bits" : (cur_rd ? "R5 frame bits" : "R4 frame bits");
    chk("R6 MDC edge count", 64'(nrise), 64'(nf * 64));
    for (int fr = 0; fr < nf; fr++) begin
      bit af, xr;
      af = cur_c45 && fr == 0;
      xr = cur_rd && !af;
      f = tb_frame(af, cur_c45, cur_rd, cur_phy, cur_a, cur_d);
      for (int p = 0; p < 64; p++) begin
        cw[63 - p] = cap_o[fr * 64 + p];
        co[63 - p] = cap_oe[fr * 64 + p];
      end
      m  = xr ? ~64'h3FFFF : '1;
      eo = xr ? ~64'h3FFFF : '1;
      chk(tag, cw & m, f & m);
      chk("R5 output enable pattern", co, eo);
    end
    chk("R7 MDC period", 64'(gap_bad), 64'd0);
    chk("R3 other buses quiet", 64'(other_rise), 64'd0);
    chk("R1 MDC low when idle", 64'(mdc), 64'd0);
    if (cur_rd) begin
      rd(A_RD, v);
      chk("R5 read data", 64'(v), 64'({16'd0, resp}));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_REXT, v); chk("R1 reset ext rate", 64'(v), 0);
    rd(A_PAR, v);  chk("R1 reset param", 64'(v), 0);
    rd(A_ST, v);   chk("R1 reset done", 64'(v), 0);
    chk("R1 reset pins", {mdc, mdio_oe, 15'd0, lockout}, 0);
    // R2 register map
    wr(A_PAR, 32'hFFFF_FFFF); rd(A_PAR, v); chk("R2 param width", 64'(v), 64'h03FF_FFFF);
    wr(A_ADR, 32'hFFFF_FFFF); rd(A_ADR, v); chk("R2 address width", 64'(v), 64'h001F_FFFF);
    wr(A_SCAN, 32'h1234_5678); rd(A_SCAN, v); chk("R2 scan readback", 64'(v), 64'h1234_5678);
    rd(10'h100, v); chk("R2 unmapped reads 0", 64'(v), 0);
    // R11 lockout
    wr(A_SCAN, 32'h1000_0000); @(negedge clk); chk("R11 lockout set", 64'(lockout), 1);
    wr(A_SCAN, 32'hEFFF_FFFF); @(negedge clk); chk("R11 lockout clear", 64'(lockout), 0);
    // rates: ext half = 2, int half = max(1,0) = 1 (R7 floor boundary)
    wr(A_REXT, {16'd1, 16'd2}); half_ext = tb_half(2, 1);
    wr(A_RINT, {16'd0, 16'd1}); half_int = tb_half(1, 0);
    rd(A_REXT, v); chk("R2 ext rate readback", 64'(v), 64'h0001_0002);
    rd(A_RINT, v); chk("R2 int rate readback", 64'(v), 64'h0000_0001);
    // R3 R4 R5 sweep over every bus port, write and read
    for (int b = 0; b < NB; b++) begin
      for (int r = 0; r < 2; r++) begin
        start_txn(b < NB / 2, 3'(b % 8), 1'b0, r[0], 5'(b * 3 + r), 21'(b * 37 + r * 5 + 21'h1A000),
                  16'hA5C3 ^ 16'(b * 16'h1111), 16'h1234 ^ 16'(b * 16'h0F0F + r));
        finish_txn();
      end
    end
    // R6 Clause-45 write and read on both groups
    start_txn(1'b1, 3'd6, 1'b1, 1'b0, 5'd9, 21'h15_BEEF, 16'h5A5A, 16'h0);
    finish_txn();
    start_txn(1'b0, 3'd2, 1'b1, 1'b1, 5'd30, 21'h0A_1234, 16'h0, 16'hC0DE);
    finish_txn();
    // R7 another ext rate: div 3 dividend 2 -> half 4
    wr(A_REXT, {16'd2, 16'd3}); half_ext = tb_half(3, 2);
    start_txn(1'b0, 3'd7, 1'b0, 1'b1, 5'd17, 21'h0001F, 16'h0, 16'h8001);
    finish_txn();
    // R9 R10 register traffic while a frame shifts
    start_txn(1'b0, 3'd4, 1'b0, 1'b0, 5'd3, 21'h00005, 16'h9C3A, 16'h0);
    repeat (100) @(negedge clk);
    wr(A_PAR, {6'd0, 1'b1, 3'd1, 1'b1, 5'd31, 16'hFFFF});
    wr(A_ADR, 32'h001F_FFFF);
    wr(A_REXT, {16'd0, 16'd1});
    wr(A_CTL, 32'd2);
    finish_txn();
    rd(A_ST, v); chk("R9 start while busy ignored", 64'(v), 1);
    wr(A_REXT, {16'd1, 16'd2}); half_ext = tb_half(2, 1);
    // R8 done clears on control 0
    wr(A_CTL, 32'd0); rd(A_ST, v); chk("R8 done cleared", 64'(v), 0);
    // R8 control value 3 starts nothing
    nrise = 0;
    wr(A_CTL, 32'd3); repeat (100) @(negedge clk);
    chk("R8 value 3 no start", 64'(nrise), 0);
    rd(A_ST, v); chk("R8 value 3 no done", 64'(v), 0);
    // R9 abort mid-frame
    start_txn(1'b1, 3'd0, 1'b0, 1'b1, 5'd1, 21'h2, 16'h0, 16'h7777);
    repeat (60) @(negedge clk);
    wr(A_CTL, 32'd0);
    rd(A_ST, v); chk("R9 abort leaves done clear", 64'(v), 0);
    k = nrise;
    repeat (200) @(negedge clk);
    chk("R9 abort stops MDC", 64'(nrise), 64'(k));
    chk("R9 abort parks pins", {mdc, mdio_oe}, 0);
    rd(A_ST, v); chk("R9 no done after abort", 64'(v), 0);
    start_txn(1'b1, 3'd0, 1'b0, 1'b1, 5'd1, 21'h2, 16'h0, 16'h7777);
    finish_txn();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule